// File: doc/BRIEF.md
# Floppy Controller Register Bank

This block is the byte-wide register bank of a floppy disk controller. A host reads and writes it over a simple single-cycle bus. Each register sits on its own 16-byte slot, and only the upper address nibble selects among the sixteen slots. The bank holds the values that the seek, read/write and formatting engines need: mode, drive select lines, setup flags, target sector, sector count, gap length and step count. It also shows the engines' results to the host: the track and sector from the last ID field seen, error flags and raw status lines.

The control byte cannot be written directly. One address clears the bits written as 1 and a second address sets them, so the host can change single control bits without a read-modify-write. Event pulses from the engines are latched in a cause register. A read of that register clears it. The interrupt line is raised when an enabled cause is pending and the master interrupt-enable control bit is on. A microsecond timer, fed by a parameterised clock prescaler, counts down to zero and then raises its own cause. Writing the software-reset bit of the setup byte returns the whole bank to zero.

Top module: `fdc_regbank`

## Requirements
- R1: The register is selected by address bits [7:4] and bits [3:0] are ignored. Slot order: 0 hold byte, 1 timer, 2 error, 3 mode, 4 select, 5 setup, 6 control-clear, 7 status/control-set, 8 cause, 9 step count, 10 current track, 11 current sector, 12 gap length, 13 target sector, 14 sector count, 15 cause enable. Plain registers read back what was written; the enable keeps bits [5:0].
- R2: Reading slot 6 returns the control byte. Writing slot 6 clears every control bit written as 1. Writing slot 7 sets every control bit written as 1. Bit 0 is the master interrupt enable.
- R3: Cause bits are: bit 5 error, bit 4 data changed, bit 3 transfer done, bit 2 seen sector, bit 1 seek done, bit 0 timer done. They stay set until slot 8 is read. The read returns the value and clears it. An event arriving in the same cycle as that read is kept.
- R4: The error register keeps only bits 7, 6, 2 and 0, ORing in pulses on err_set. Reading it clears it. The error cause is latched only when a valid error bit goes from 0 to 1.
- R5: irq is high exactly when (cause AND enable) is nonzero and control bit 0 is 1.
- R6: Reading slot 7 gives {fifo1, fifo2, error-register-nonzero, 0, sense, raw-read, enabled-cause-pending, mark} from bit 7 down to bit 0.
- R7: After a timer write of N, the timer decrements once every CLK_PER_US clocks and reaches 0 N*CLK_PER_US cycles after the write. It then stays at 0. The timer-done cause is latched on the 1-to-0 step only.
- R8: A write to the setup slot with bit 7 set clears every register, cause and enable to zero on the next edge.
- R9: After reset every readable register is 0 and irq is low.
- R10: Current track and sector are loaded only by id_load. Host writes to slots 2, 8, 10 and 11 have no effect.
- R11: Each ev_step pulse decrements the step count, which stops at zero. A host write to that slot takes priority over a step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed slot |
| ev_seek_done | input | 1 | Seek finished pulse |
| ev_seen_sector | input | 1 | Sector ID seen pulse |
| ev_xfer_done | input | 1 | Transfer finished pulse |
| ev_data_changed | input | 1 | Data-changed pulse |
| ev_step | input | 1 | One head step issued |
| id_load | input | 1 | Load current track and sector |
| id_track | input | 8 | Track number from ID field |
| id_sector | input | 8 | Sector number from ID field |
| err_set | input | 8 | Error bits to set |
| sts_fifo1 | input | 1 | FIFO holds one byte |
| sts_fifo2 | input | 1 | FIFO holds two bytes |
| sts_sense | input | 1 | Drive sense line |
| sts_rdraw | input | 1 | Raw read data line |
| sts_mark | input | 1 | Mark byte flag |
| hold_byte | output | 8 | Hold byte register |
| mode_byte | output | 8 | Mode register |
| sel_byte | output | 8 | Drive select register |
| setup_byte | output | 8 | Setup register |
| ctrl_byte | output | 8 | Control register |
| seek_count | output | 8 | Remaining step count |
| gap_len | output | 8 | Gap length |
| tgt_sector | output | 8 | Target sector |
| sect_count | output | 8 | Sector count |
| irq | output | 1 | Interrupt request |

## Verification
The bench reads the cause register in the same cycle as a new event arrives. A design whose clear wins over the set would lose that interrupt for good. The error cause is checked for a repeated error bit and for an invalid one. A bank that raises the cause on every pulse would show a cause that no new fault made. The timer is sampled one cycle before and one cycle on the expected zero, and again long after. This catches an off-by-one prescaler, a counter that wraps through 255, or a done cause that fires more than once. Writes to the read-only slots, a step at zero, and a software reset with live state are read back to show nothing leaks through.

// File: rtl/fdc_regbank_pkg.sv
package fdc_regbank_pkg;

  typedef enum logic [3:0] {
    RI_HOLD     = 4'd0,
    RI_TIMER    = 4'd1,
    RI_ERROR    = 4'd2,
    RI_MODE     = 4'd3,
    RI_SELECT   = 4'd4,
    RI_SETUP    = 4'd5,
    RI_CTRL_CLR = 4'd6,
    RI_CTRL_SET = 4'd7,
    RI_CAUSE    = 4'd8,
    RI_NSTEP    = 4'd9,
    RI_CTRACK   = 4'd10,
    RI_CSECT    = 4'd11,
    RI_GAP      = 4'd12,
    RI_TSECT    = 4'd13,
    RI_SCOUNT   = 4'd14,
    RI_CAUSE_EN = 4'd15
  } reg_idx_e;

  localparam int CAUSE_W   = 6;
  localparam int CB_ERR    = 5;
  localparam int CB_DCHG   = 4;
  localparam int CB_XFER   = 3;
  localparam int CB_SEEN   = 2;
  localparam int CB_SEEK   = 1;
  localparam int CB_TIMER  = 0;

  localparam logic [7:0] ERR_VALID = 8'hC5;
  localparam int SETUP_SWRST = 7;
  localparam int CTRL_IRQ_EN = 0;

endpackage

// File: rtl/fdc_us_timer.sv
module fdc_us_timer #(
  parameter int CLK_PER_US = 250,
  parameter int CNT_W      = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_clr,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] count,
  output logic             expire
);
  localparam int PRE_W = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CLK_PER_US - 1);

  logic [PRE_W-1:0] pre_q, pre_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             tick;

  assign tick  = (pre_q == PRE_LAST);
  assign count = cnt_q;

  always_comb begin
    pre_d  = pre_q;
    cnt_d  = cnt_q;
    expire = 1'b0;
    if (soft_clr) begin
      pre_d = '0;
      cnt_d = '0;
    end else if (load) begin
      pre_d = '0;
      cnt_d = load_val;
    end else begin
      pre_d = tick ? '0 : pre_q + 1'b1;
      if (tick && (cnt_q != '0)) begin
        cnt_d  = cnt_q - 1'b1;
        expire = (cnt_q == CNT_W'(1));
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else begin
      pre_q <= pre_d;
      cnt_q <= cnt_d;
    end
  end

  // R7: an idle counter at zero stays there
  p_timer_floor_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0 && !load) |=> (cnt_q == '0));

  // R7: each prescaler wrap removes exactly one count
  p_timer_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt_q != '0 && !load && !soft_clr) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/fdc_irq_latch.sv
module fdc_irq_latch #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         soft_clr,
  input  logic [W-1:0] ev,
  input  logic         rd_clr,
  output logic [W-1:0] cause
);
  logic [W-1:0] cause_d;

  always_comb begin
    if (soft_clr)    cause_d = '0;
    else if (rd_clr) cause_d = ev;
    else             cause_d = cause | ev;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cause <= '0;
    else        cause <= cause_d;
  end

  // R3: causes are sticky until read
  p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_clr && !soft_clr) |=> ((cause & $past(cause)) == $past(cause)));

  // R3: a read with no new event leaves nothing pending
  p_read_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && ev == '0) |=> (cause == '0));

endmodule

// File: rtl/fdc_err_latch.sv
module fdc_err_latch #(
  parameter int         W     = 8,
  parameter logic [W-1:0] VALID = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         soft_clr,
  input  logic [W-1:0] set_bits,
  input  logic         rd_clr,
  output logic [W-1:0] err,
  output logic         new_err
);
  logic [W-1:0] set_v, err_d;

  assign set_v   = set_bits & VALID;
  assign new_err = |(set_v & ~err);

  always_comb begin
    if (soft_clr)    err_d = '0;
    else if (rd_clr) err_d = set_v;
    else             err_d = err | set_v;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err <= '0;
    else        err <= err_d;
  end

  // R4: only valid positions can ever be held
  p_err_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (err & ~VALID) == '0);

  // R4: read with no incoming fault empties the register
  p_err_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && set_v == '0) |=> (err == '0));

endmodule

// File: rtl/fdc_regbank.sv
module fdc_regbank #(
  parameter int CLK_PER_US = 250,
  parameter int ADDR_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              ev_seek_done,
  input  logic              ev_seen_sector,
  input  logic              ev_xfer_done,
  input  logic              ev_data_changed,
  input  logic              ev_step,
  input  logic              id_load,
  input  logic [7:0]        id_track,
  input  logic [7:0]        id_sector,
  input  logic [7:0]        err_set,
  input  logic              sts_fifo1,
  input  logic              sts_fifo2,
  input  logic              sts_sense,
  input  logic              sts_rdraw,
  input  logic              sts_mark,
  output logic [7:0]        hold_byte,
  output logic [7:0]        mode_byte,
  output logic [7:0]        sel_byte,
  output logic [7:0]        setup_byte,
  output logic [7:0]        ctrl_byte,
  output logic [7:0]        seek_count,
  output logic [7:0]        gap_len,
  output logic [7:0]        tgt_sector,
  output logic [7:0]        sect_count,
  output logic              irq
);
  import fdc_regbank_pkg::*;

  localparam int IDX_LSB = ADDR_W - 4;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  // bus decode
  reg_idx_e idx;
  logic     wr, rd, soft_clr;

  assign idx      = reg_idx_e'(bus_addr[ADDR_W-1:IDX_LSB]);
  assign wr       = bus_sel & bus_we;
  assign rd       = bus_sel & ~bus_we;
  assign soft_clr = wr && (idx == RI_SETUP) && bus_wdata[SETUP_SWRST];

  // plain registers
  logic [7:0] hold_q, mode_q, sel_q, setup_q, ctrl_q, nstep_q;
  logic [7:0] ctrack_q, csect_q, gap_q, tsect_q, scount_q;
  logic [CAUSE_W-1:0] cen_q;
  logic [7:0] hold_d, mode_d, sel_d, setup_d, ctrl_d, nstep_d;
  logic [7:0] ctrack_d, csect_d, gap_d, tsect_d, scount_d;
  logic [CAUSE_W-1:0] cen_d;

  always_comb begin
    hold_d   = hold_q;
    mode_d   = mode_q;
    sel_d    = sel_q;
    setup_d  = setup_q;
    ctrl_d   = ctrl_q;
    nstep_d  = nstep_q;
    ctrack_d = ctrack_q;
    csect_d  = csect_q;
    gap_d    = gap_q;
    tsect_d  = tsect_q;
    scount_d = scount_q;
    cen_d    = cen_q;

    if (ev_step && (nstep_q != 8'd0)) nstep_d = nstep_q - 8'd1;
    if (id_load) begin
      ctrack_d = id_track;
      csect_d  = id_sector;
    end

    if (wr) begin
      unique case (idx)
        RI_HOLD:     hold_d   = bus_wdata;
        RI_MODE:     mode_d   = bus_wdata;
        RI_SELECT:   sel_d    = bus_wdata;
        RI_SETUP:    setup_d  = bus_wdata;
        RI_CTRL_CLR: ctrl_d   = ctrl_q & ~bus_wdata;
        RI_CTRL_SET: ctrl_d   = ctrl_q | bus_wdata;
        RI_NSTEP:    nstep_d  = bus_wdata;
        RI_GAP:      gap_d    = bus_wdata;
        RI_TSECT:    tsect_d  = bus_wdata;
        RI_SCOUNT:   scount_d = bus_wdata;
        RI_CAUSE_EN: cen_d    = bus_wdata[CAUSE_W-1:0];
        default: ;
      endcase
    end

    if (soft_clr) begin
      hold_d   = '0;
      mode_d   = '0;
      sel_d    = '0;
      setup_d  = '0;
      ctrl_d   = '0;
      nstep_d  = '0;
      ctrack_d = '0;
      csect_d  = '0;
      gap_d    = '0;
      tsect_d  = '0;
      scount_d = '0;
      cen_d    = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      hold_q   <= '0;
      mode_q   <= '0;
      sel_q    <= '0;
      setup_q  <= '0;
      ctrl_q   <= '0;
      nstep_q  <= '0;
      ctrack_q <= '0;
      csect_q  <= '0;
      gap_q    <= '0;
      tsect_q  <= '0;
      scount_q <= '0;
      cen_q    <= '0;
    end else begin
      hold_q   <= hold_d;
      mode_q   <= mode_d;
      sel_q    <= sel_d;
      setup_q  <= setup_d;
      ctrl_q   <= ctrl_d;
      nstep_q  <= nstep_d;
      ctrack_q <= ctrack_d;
      csect_q  <= csect_d;
      gap_q    <= gap_d;
      tsect_q  <= tsect_d;
      scount_q <= scount_d;
      cen_q    <= cen_d;
    end
  end

  // timer
  logic [7:0] tmr_count;
  logic       tmr_expire;

  fdc_us_timer #(.CLK_PER_US(CLK_PER_US), .CNT_W(8)) u_timer (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .soft_clr (soft_clr),
    .load     (wr && (idx == RI_TIMER)),
    .load_val (bus_wdata),
    .count    (tmr_count),
    .expire   (tmr_expire)
  );

  // error flags
  logic [7:0] err_q;
  logic       err_new;

  fdc_err_latch #(.W(8), .VALID(ERR_VALID)) u_err (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .soft_clr (soft_clr),
    .set_bits (err_set),
    .rd_clr   (rd && (idx == RI_ERROR)),
    .err      (err_q),
    .new_err  (err_new)
  );

  // interrupt causes
  logic [CAUSE_W-1:0] ev_vec, cause_q;
  logic               pend;

  always_comb begin
    ev_vec           = '0;
    ev_vec[CB_ERR]   = err_new;
    ev_vec[CB_DCHG]  = ev_data_changed;
    ev_vec[CB_XFER]  = ev_xfer_done;
    ev_vec[CB_SEEN]  = ev_seen_sector;
    ev_vec[CB_SEEK]  = ev_seek_done;
    ev_vec[CB_TIMER] = tmr_expire;
  end

  fdc_irq_latch #(.W(CAUSE_W)) u_cause (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .soft_clr (soft_clr),
    .ev       (ev_vec),
    .rd_clr   (rd && (idx == RI_CAUSE)),
    .cause    (cause_q)
  );

  assign pend = |(cause_q & cen_q);
  assign irq  = pend & ctrl_q[CTRL_IRQ_EN];

  // read mux
  always_comb begin
    unique case (idx)
      RI_HOLD:     bus_rdata = hold_q;
      RI_TIMER:    bus_rdata = tmr_count;
      RI_ERROR:    bus_rdata = err_q;
      RI_MODE:     bus_rdata = mode_q;
      RI_SELECT:   bus_rdata = sel_q;
      RI_SETUP:    bus_rdata = setup_q;
      RI_CTRL_CLR: bus_rdata = ctrl_q;
      RI_CTRL_SET: bus_rdata = {sts_fifo1, sts_fifo2, (err_q != 8'd0), 1'b0,
                                sts_sense, sts_rdraw, pend, sts_mark};
      RI_CAUSE:    bus_rdata = {{(8-CAUSE_W){1'b0}}, cause_q};
      RI_NSTEP:    bus_rdata = nstep_q;
      RI_CTRACK:   bus_rdata = ctrack_q;
      RI_CSECT:    bus_rdata = csect_q;
      RI_GAP:      bus_rdata = gap_q;
      RI_TSECT:    bus_rdata = tsect_q;
      RI_SCOUNT:   bus_rdata = scount_q;
      RI_CAUSE_EN: bus_rdata = {{(8-CAUSE_W){1'b0}}, cen_q};
      default:     bus_rdata = 8'd0;
    endcase
  end

  assign hold_byte  = hold_q;
  assign mode_byte  = mode_q;
  assign sel_byte   = sel_q;
  assign setup_byte = setup_q;
  assign ctrl_byte  = ctrl_q;
  assign seek_count = nstep_q;
  assign gap_len    = gap_q;
  assign tgt_sector = tsect_q;
  assign sect_count = scount_q;

  // R2: a set-address write leaves every written bit on
  p_ctrl_set_r2: assert property (@(posedge clk) disable iff (!rst_i_n)
    (wr && idx == RI_CTRL_SET) |=> ((ctrl_q & $past(bus_wdata)) == $past(bus_wdata)));

  // R5: dropping the master enable silences the line next cycle
  p_irq_gate_r5: assert property (@(posedge clk) disable iff (!rst_i_n)
    (wr && idx == RI_CTRL_CLR && bus_wdata[CTRL_IRQ_EN]) |=> !irq);

  // R8: software reset empties control, setup, enable and causes
  p_swrst_r8: assert property (@(posedge clk) disable iff (!rst_i_n)
    soft_clr |=> (ctrl_q == 8'd0 && setup_q == 8'd0 && cen_q == '0 && cause_q == '0));

  // R10: host writes cannot move the current track
  p_ctrack_ro_r10: assert property (@(posedge clk) disable iff (!rst_i_n)
    (wr && idx == RI_CTRACK && !id_load) |=> $stable(ctrack_q));

  // R11: the step count never wraps below zero
  p_nstep_floor_r11: assert property (@(posedge clk) disable iff (!rst_i_n)
    (nstep_q == 8'd0 && !(wr && idx == RI_NSTEP)) |=> (nstep_q == 8'd0));

endmodule

// File: tb/fdc_regbank_bench.sv
module fdc_regbank_bench;
  localparam int DIV = 5;
  localparam int NV  = 30;

  // {is_write, addr, data, expected_read}
  localparam logic [24:0] VEC [0:NV-1] = '{
    {1'b1, 8'h30, 8'h95, 8'h00}, {1'b0, 8'h30, 8'h00, 8'h95},
    {1'b1, 8'h3C, 8'h12, 8'h00}, {1'b0, 8'h37, 8'h00, 8'h12},
    {1'b1, 8'h90, 8'h07, 8'h00}, {1'b0, 8'h90, 8'h00, 8'h07},
    {1'b1, 8'hC0, 8'h22, 8'h00}, {1'b0, 8'hC8, 8'h00, 8'h22},
    {1'b1, 8'hD0, 8'h05, 8'h00}, {1'b0, 8'hD0, 8'h00, 8'h05},
    {1'b1, 8'hE0, 8'h09, 8'h00}, {1'b0, 8'hE0, 8'h00, 8'h09},
    {1'b1, 8'h70, 8'hF0, 8'h00}, {1'b0, 8'h60, 8'h00, 8'hF0},
    {1'b1, 8'h60, 8'h30, 8'h00}, {1'b0, 8'h60, 8'h00, 8'hC0},
    {1'b1, 8'h70, 8'h01, 8'h00}, {1'b0, 8'h60, 8'h00, 8'hC1},
    {1'b1, 8'h60, 8'hFF, 8'h00}, {1'b0, 8'h60, 8'h00, 8'h00},
    {1'b1, 8'h40, 8'h0A, 8'h00}, {1'b0, 8'h40, 8'h00, 8'h0A},
    {1'b1, 8'h00, 8'h5A, 8'h00}, {1'b0, 8'h0F, 8'h00, 8'h5A},
    {1'b1, 8'hF0, 8'hFF, 8'h00}, {1'b0, 8'hF0, 8'h00, 8'h3F},
    {1'b1, 8'h50, 8'h28, 8'h00}, {1'b0, 8'h50, 8'h00, 8'h28},
    {1'b1, 8'h60, 8'h00, 8'h00}, {1'b0, 8'h60, 8'h00, 8'h00}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic bus_sel, bus_we;
  logic [7:0] bus_addr, bus_wdata, bus_rdata;
  logic ev_seek_done, ev_seen_sector, ev_xfer_done, ev_data_changed, ev_step;
  logic id_load;
  logic [7:0] id_track, id_sector, err_set;
  logic sts_fifo1, sts_fifo2, sts_sense, sts_rdraw, sts_mark;
  logic [7:0] hold_byte, mode_byte, sel_byte, setup_byte, ctrl_byte;
  logic [7:0] seek_count, gap_len, tgt_sector, sect_count;
  logic irq;

  int checks = 0;
  int fails  = 0;
  logic [7:0] rv;

  always #2 clk = ~clk;

  fdc_regbank #(.CLK_PER_US(DIV), .ADDR_W(8)) u_fdc_regbank (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ev_seek_done(ev_seek_done), .ev_seen_sector(ev_seen_sector),
    .ev_xfer_done(ev_xfer_done), .ev_data_changed(ev_data_changed),
    .ev_step(ev_step), .id_load(id_load), .id_track(id_track),
    .id_sector(id_sector), .err_set(err_set), .sts_fifo1(sts_fifo1),
    .sts_fifo2(sts_fifo2), .sts_sense(sts_sense), .sts_rdraw(sts_rdraw),
    .sts_mark(sts_mark), .hold_byte(hold_byte), .mode_byte(mode_byte),
    .sel_byte(sel_byte), .setup_byte(setup_byte), .ctrl_byte(ctrl_byte),
    .seek_count(seek_count), .gap_len(gap_len), .tgt_sector(tgt_sector),
    .sect_count(sect_count), .irq(irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd_reg(input logic [7:0] a, output logic [7:0] d);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic pulse_err(input logic [7:0] b);
    err_set = b;
    @(negedge clk);
    err_set = 8'h00;
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_sel = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    ev_seek_done = 0; ev_seen_sector = 0; ev_xfer_done = 0; ev_data_changed = 0;
    ev_step = 0; id_load = 0; id_track = '0; id_sector = '0; err_set = '0;
    sts_fifo1 = 0; sts_fifo2 = 0; sts_sense = 0; sts_rdraw = 0; sts_mark = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R9: reset state of every slot
    for (int i = 0; i < 16; i++) begin
      rd_reg(8'(i * 16), rv);
      chk("R9", rv, 8'h00);
    end
    chk("R9 irq", {7'd0, irq}, 8'h00);

    // R1 R2: table walk
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][24]) wr_reg(VEC[i][23:16], VEC[i][15:8]);
      else begin
        rd_reg(VEC[i][23:16], rv);
        chk("R1/R2 table", rv, VEC[i][7:0]);
      end
    end

    // R10: read-only slots ignore writes
    wr_reg(8'hA0, 8'h55);
    wr_reg(8'hB0, 8'h66);
    wr_reg(8'h20, 8'hFF);
    wr_reg(8'h80, 8'h3F);
    rd_reg(8'hA0, rv); chk("R10 track", rv, 8'h00);
    rd_reg(8'hB0, rv); chk("R10 sector", rv, 8'h00);
    rd_reg(8'h20, rv); chk("R10 error", rv, 8'h00);
    rd_reg(8'h80, rv); chk("R10 cause", rv, 8'h00);
    id_track = 8'h12; id_sector = 8'h07; id_load = 1'b1;
    @(negedge clk);
    id_load = 1'b0;
    rd_reg(8'hA0, rv); chk("R10 track load", rv, 8'h12);
    rd_reg(8'hB0, rv); chk("R10 sector load", rv, 8'h07);

    // R4: error latch and error cause
    pulse_err(8'h80);
    rd_reg(8'h20, rv); chk("R4 err read", rv, 8'h80);
    rd_reg(8'h20, rv); chk("R4 err cleared", rv, 8'h00);
    rd_reg(8'h80, rv); chk("R4 err cause", rv, 8'h20);
    pulse_err(8'h04);
    rd_reg(8'h80, rv); chk("R4 new bit cause", rv, 8'h20);
    pulse_err(8'h04);
    rd_reg(8'h80, rv); chk("R4 repeat no cause", rv, 8'h00);
    pulse_err(8'h02);
    rd_reg(8'h20, rv); chk("R4 masked bit", rv, 8'h04);
    rd_reg(8'h80, rv); chk("R4 masked no cause", rv, 8'h00);

    // R6: status composition (enable is 0x3F from table)
    sts_fifo1 = 1; sts_sense = 1; sts_mark = 1;
    rd_reg(8'h70, rv); chk("R6 status", rv, 8'h89);
    pulse_err(8'h40);
    rd_reg(8'h70, rv); chk("R6 status err+pend", rv, 8'hAB);
    sts_fifo1 = 0; sts_sense = 0; sts_mark = 0;
    sts_fifo2 = 1; sts_rdraw = 1;
    rd_reg(8'h20, rv);
    rd_reg(8'h80, rv);
    rd_reg(8'h70, rv); chk("R6 status clean", rv, 8'h44);
    sts_fifo2 = 0; sts_rdraw = 0;

    // R3: read clears, concurrent event survives
    ev_xfer_done = 1; @(negedge clk); ev_xfer_done = 0;
    rd_reg(8'h80, rv); chk("R3 cause", rv, 8'h08);
    rd_reg(8'h80, rv); chk("R3 cleared", rv, 8'h00);
    ev_data_changed = 1; @(negedge clk); ev_data_changed = 0;
    bus_sel = 1; bus_we = 0; bus_addr = 8'h80; ev_seen_sector = 1;
    #1 rv = bus_rdata;
    @(negedge clk);
    bus_sel = 0; ev_seen_sector = 0;
    chk("R3 read during event", rv, 8'h10);
    rd_reg(8'h80, rv); chk("R3 event kept", rv, 8'h04);

    // R5: interrupt gating
    wr_reg(8'hF0, 8'h04);
    ev_seen_sector = 1; @(negedge clk); ev_seen_sector = 0;
    chk("R5 master off", {7'd0, irq}, 8'h00);
    wr_reg(8'h70, 8'h01);
    chk("R5 master on", {7'd0, irq}, 8'h01);
    wr_reg(8'h60, 8'h01);
    chk("R5 master cleared", {7'd0, irq}, 8'h00);
    wr_reg(8'h70, 8'h01);
    wr_reg(8'hF0, 8'h02);
    chk("R5 cause masked", {7'd0, irq}, 8'h00);
    wr_reg(8'hF0, 8'h04);
    chk("R5 cause unmasked", {7'd0, irq}, 8'h01);
    rd_reg(8'h80, rv);
    chk("R5 after read", {7'd0, irq}, 8'h00);
    wr_reg(8'hF0, 8'h3F);

    // R7: timer countdown
    wr_reg(8'h10, 8'd3);
    repeat (3 * DIV - 2) @(negedge clk);
    rd_reg(8'h10, rv); chk("R7 timer one", rv, 8'h01);
    rd_reg(8'h80, rv); chk("R7 no done yet", rv, 8'h00);
    rd_reg(8'h10, rv); chk("R7 timer zero", rv, 8'h00);
    chk("R7 irq", {7'd0, irq}, 8'h01);
    rd_reg(8'h80, rv); chk("R7 done cause", rv, 8'h01);
    repeat (4 * DIV) @(negedge clk);
    rd_reg(8'h10, rv); chk("R7 stays zero", rv, 8'h00);
    rd_reg(8'h80, rv); chk("R7 no refire", rv, 8'h00);

    // R11: step count
    wr_reg(8'h90, 8'd2);
    ev_step = 1; @(negedge clk); ev_step = 0;
    rd_reg(8'h90, rv); chk("R11 one step", rv, 8'h01);
    ev_step = 1; repeat (3) @(negedge clk); ev_step = 0;
    rd_reg(8'h90, rv); chk("R11 floor", rv, 8'h00);
    ev_step = 1;
    wr_reg(8'h90, 8'd9);
    ev_step = 0;
    rd_reg(8'h90, rv); chk("R11 write wins", rv, 8'h09);

    // R8: software reset
    wr_reg(8'h30, 8'h55);
    wr_reg(8'h70, 8'hFF);
    ev_seek_done = 1; @(negedge clk); ev_seek_done = 0;
    wr_reg(8'h10, 8'h40);
    wr_reg(8'h50, 8'h80);
    rd_reg(8'h30, rv); chk("R8 mode", rv, 8'h00);
    rd_reg(8'h60, rv); chk("R8 ctrl", rv, 8'h00);
    rd_reg(8'h50, rv); chk("R8 setup", rv, 8'h00);
    rd_reg(8'h10, rv); chk("R8 timer", rv, 8'h00);
    rd_reg(8'hF0, rv); chk("R8 enable", rv, 8'h00);
    rd_reg(8'hA0, rv); chk("R8 track", rv, 8'h00);
    rd_reg(8'h80, rv); chk("R8 cause", rv, 8'h00);
    chk("R8 irq", {7'd0, irq}, 8'h00);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule